// File: doc/BRIEF.md
# Programmable GPIO Flag Controller

A bank of general-purpose flag pins driven and observed through a small register bus. Every pin carries its own direction bit. Output levels are changed either with one full-width data write or through three write-one-to-modify registers that raise, lower or invert any chosen subset of pins in one bus cycle, leaving the other pins untouched, so software never needs a read-modify-write.

Each pin can also raise an interrupt. Inputs pass through a two-flop synchronizer. The pin sense, which is the output latch for an output pin and the synchronized input for an input pin, feeds a per-pin detector that works in level mode, rising-edge mode or both-edges mode. Edges latch into sticky status bits that software clears by writing ones. Interrupt enables are changed only through separate enable-set and enable-clear registers. A registered OR of enabled status bits forms the single interrupt line. Because the detector watches the sense, a software write to an output pin can trigger an interrupt.

Top module: `gpio_flag_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, pin_o, pin_oe_o, irq_o and every register read as zero.
- R2: A write to address 0 loads the direction register (bit = 1 makes that pin an output). pin_oe_o shows it from the next clock. Reading address 0 returns it.
- R3: A write to address 2 drives every output-latch bit written as 1 high from the next clock. Bits written as 0 keep their value.
- R4: A write to address 3 drives every output-latch bit written as 1 low. Bits written as 0 keep their value.
- R5: A write to address 4 inverts every output-latch bit written as 1. Bits written as 0 keep their value.
- R6: A write to address 1 loads the whole output latch. Reads of addresses 1 to 4 return the latch, and pin_o always shows it.
- R7: Reading address 5 returns the pin sense: the latch bit for an output pin, and for an input pin the level that pin_i had two clocks earlier. Writes to address 5 and to unmapped addresses 11 to 15 change nothing, and unmapped reads return zero.
- R8: Writing 1s to address 6 sets those interrupt-enable bits. Writing 1s to address 7 clears them. Zeros leave a bit unchanged. Reads of 6 and 7 return the enables.
- R9: Address 8 selects the mode per pin (0 = level, 1 = edge). In level mode the status bit read at address 10 equals the current pin sense. irq_o is high one clock after any status bit and its enable are both 1, and low one clock after none are.
- R10: Address 9 selects, for an edge-mode pin, rising only (0) or both edges (1). A detected edge of the sense sets a sticky status bit one clock later. Writing 1 to that bit at address 10 clears it, and an edge in the same cycle wins over the clear.
- R11: Edges of an output pin's sense caused by software writes set status exactly as input activity does.
- R12: Any register write takes effect on the next clock. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 16 | Write data, one bit per pin |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| pin_i | input | 16 | Asynchronous pin levels |
| pin_o | output | 16 | Output latch |
| pin_oe_o | output | 16 | Output enable per pin (direction) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with its default of 16 pins and a 4-bit address. This puts the full width in play: outputs and inputs mixed inside one bus word, the top and bottom pin of each register field, and the unmapped addresses above the last register. A behavioural model compares read data on every cycle before the clock edge, and the pin, enable and interrupt outputs after it. The stimulus mixes directed sequences that cover sticky status, clear against edge collisions and software-made edges with a long random stretch of writes, reads and pin activity.

// File: rtl/gpio_flag_pkg.sv
package gpio_flag_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR     = 4'd0,
    REG_DATA    = 4'd1,
    REG_SET     = 4'd2,
    REG_CLR     = 4'd3,
    REG_TGL     = 4'd4,
    REG_SENSE   = 4'd5,
    REG_IEN_SET = 4'd6,
    REG_IEN_CLR = 4'd7,
    REG_MODE    = 4'd8,
    REG_BOTH    = 4'd9,
    REG_ISTAT   = 4'd10
  } reg_addr_e;
endpackage

// File: rtl/gpio_flag_sync.sv
module gpio_flag_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_flag_regs.sv
module gpio_flag_regs
  import gpio_flag_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N-1:0]      bus_wdata_i,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      out_o,
  output logic [N-1:0]      ien_o,
  output logic [N-1:0]      mode_o,
  output logic [N-1:0]      both_o,
  output logic [N-1:0]      stat_clr_o
);
  logic [N-1:0] dir_q, out_q, ien_q, mode_q, both_q;
  logic [N-1:0] out_d, ien_d;

  always_comb begin
    out_d = out_q;
    ien_d = ien_q;
    if (bus_we_i) begin
      unique case (bus_addr_i)
        REG_DATA:    out_d = bus_wdata_i;
        REG_SET:     out_d = out_q | bus_wdata_i;
        REG_CLR:     out_d = out_q & ~bus_wdata_i;
        REG_TGL:     out_d = out_q ^ bus_wdata_i;
        REG_IEN_SET: ien_d = ien_q | bus_wdata_i;
        REG_IEN_CLR: ien_d = ien_q & ~bus_wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      out_q  <= '0;
      ien_q  <= '0;
      mode_q <= '0;
      both_q <= '0;
    end else begin
      out_q <= out_d;
      ien_q <= ien_d;
      if (bus_we_i && bus_addr_i == REG_DIR)  dir_q  <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == REG_MODE) mode_q <= bus_wdata_i;
      if (bus_we_i && bus_addr_i == REG_BOTH) both_q <= bus_wdata_i;
    end
  end

  assign stat_clr_o = (bus_we_i && bus_addr_i == REG_ISTAT) ? bus_wdata_i : '0;
  assign dir_o  = dir_q;
  assign out_o  = out_q;
  assign ien_o  = ien_q;
  assign mode_o = mode_q;
  assign both_o = both_q;

  a_r3_set_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_SET) |=> ((out_q & $past(bus_wdata_i)) == $past(bus_wdata_i)));
  a_r4_clr_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_CLR) |=> ((out_q & $past(bus_wdata_i)) == '0));
  a_r5_tgl_inverts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_TGL) |=> (out_q == ($past(out_q) ^ $past(bus_wdata_i))));
  a_r8_ien_clr_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i == REG_IEN_CLR) |=> ((ien_q & $past(bus_wdata_i)) == '0));
  a_r2_dir_stable_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_flag_irq.sv
module gpio_flag_irq #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sense_i,
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] both_i,
  input  logic [N-1:0] ien_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] sense_q, stk_q, hit;
  logic         irq_q;

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic rise, fall;
    assign rise   = sense_i[g] & ~sense_q[g];
    assign fall   = ~sense_i[g] & sense_q[g];
    assign hit[g] = mode_i[g] & (rise | (both_i[g] & fall));

    // edge set has priority over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         stk_q[g] <= 1'b0;
      else if (!mode_i[g]) stk_q[g] <= 1'b0;
      else if (hit[g])     stk_q[g] <= 1'b1;
      else if (clr_i[g])   stk_q[g] <= 1'b0;
    end

    assign status_o[g] = mode_i[g] ? stk_q[g] : sense_i[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      sense_q <= sense_i;
      irq_q   <= |(status_o & ien_i);
    end
  end

  assign irq_o = irq_q;

  a_r10_edge_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((stk_q & $past(hit)) == $past(hit)));
  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |=> !irq_o);
  a_r10_no_spurious_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0 && stk_q == '0) |=> (stk_q == '0));
endmodule

// File: rtl/gpio_flag_ctrl.sv
module gpio_flag_ctrl
  import gpio_flag_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int N = NUM_PINS;

  logic [N-1:0] dir, outv, ien, mode, both, stat_clr;
  logic [N-1:0] pin_sync, sense, status;

  gpio_flag_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_flag_regs #(.N(N)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_we_i   (bus_we_i),
    .bus_addr_i (bus_addr_i),
    .bus_wdata_i(bus_wdata_i),
    .dir_o      (dir),
    .out_o      (outv),
    .ien_o      (ien),
    .mode_o     (mode),
    .both_o     (both),
    .stat_clr_o (stat_clr)
  );

  assign sense = (dir & outv) | (~dir & pin_sync);

  gpio_flag_irq #(.N(N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sense_i (sense),
    .mode_i  (mode),
    .both_i  (both),
    .ien_i   (ien),
    .clr_i   (stat_clr),
    .status_o(status),
    .irq_o   (irq_o)
  );

  always_comb begin
    unique case (bus_addr_i)
      REG_DIR:                                 bus_rdata_o = dir;
      REG_DATA, REG_SET, REG_CLR, REG_TGL:     bus_rdata_o = outv;
      REG_SENSE:                               bus_rdata_o = sense;
      REG_IEN_SET, REG_IEN_CLR:                bus_rdata_o = ien;
      REG_MODE:                                bus_rdata_o = mode;
      REG_BOTH:                                bus_rdata_o = both;
      REG_ISTAT:                               bus_rdata_o = status;
      default:                                 bus_rdata_o = '0;
    endcase
  end

  assign pin_o    = outv;
  assign pin_oe_o = dir;

  a_r6_pin_out_stable_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(pin_o));
endmodule

// File: tb/gpio_flag_ctrl_bench.sv
module gpio_flag_ctrl_bench;
  localparam int N  = 16;
  localparam int AW = gpio_flag_pkg::ADDR_W;

  logic          clk, rst_n, we, irq;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata, rdata, pins, pout, poe;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  gpio_flag_ctrl u_gpio_flag_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
    .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference state
  logic [N-1:0] m_dir, m_out, m_ien, m_mode, m_both, m_stk, m_prev;
  logic         m_irq;
  logic [N-1:0] hist[$];

  function automatic logic [N-1:0] m_sense();
    logic [N-1:0] s;
    for (int i = 0; i < N; i++) s[i] = m_dir[i] ? m_out[i] : hist[0][i];
    return s;
  endfunction

  function automatic logic [N-1:0] m_status();
    logic [N-1:0] s, sn;
    sn = m_sense();
    for (int i = 0; i < N; i++) s[i] = m_mode[i] ? m_stk[i] : sn[i];
    return s;
  endfunction

  function automatic logic [N-1:0] m_read(int a);
    case (a)
      0:             return m_dir;
      1, 2, 3, 4:    return m_out;
      5:             return m_sense();
      6, 7:          return m_ien;
      8:             return m_mode;
      9:             return m_both;
      10:            return m_status();
      default:       return '0;
    endcase
  endfunction

  task automatic m_reset();
    m_dir = '0; m_out = '0; m_ien = '0; m_mode = '0; m_both = '0;
    m_stk = '0; m_prev = '0; m_irq = 1'b0;
    hist.delete(); hist.push_back('0); hist.push_back('0);
  endtask

  task automatic m_clock(bit w, int a, logic [N-1:0] d, logic [N-1:0] p);
    logic [N-1:0] sn, st, nstk;
    sn = m_sense();
    st = m_status();
    for (int i = 0; i < N; i++) begin
      bit edge_seen;
      edge_seen = (sn[i] && !m_prev[i]) || (m_both[i] && !sn[i] && m_prev[i]);
      if (!m_mode[i])                         nstk[i] = 1'b0;
      else if (edge_seen)                     nstk[i] = 1'b1;
      else if (w && a == 10 && d[i])          nstk[i] = 1'b0;
      else                                    nstk[i] = m_stk[i];
    end
    m_irq  = (st & m_ien) != '0;
    m_stk  = nstk;
    m_prev = sn;
    if (w) begin
      case (a)
        0: m_dir = d;
        1: m_out = d;
        2: m_out = m_out | d;
        3: m_out = m_out & ~d;
        4: m_out = m_out ^ d;
        6: m_ien = m_ien | d;
        7: m_ien = m_ien & ~d;
        8: m_mode = d;
        9: m_both = d;
        default: ;
      endcase
    end
    void'(hist.pop_front());
    hist.push_back(p);
  endtask

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one bus cycle: drive after negedge, check read before posedge, outputs after
  task automatic step(bit w, int a, logic [N-1:0] d, logic [N-1:0] p);
    we = w; addr = AW'(a); wdata = d; pins = p;
    #1;
    check($sformatf("R12/R7 read addr %0d", a), rdata, m_read(a));
    @(posedge clk);
    m_clock(w, a, d, p);
    @(negedge clk);
    check("R2 pin_oe_o", poe, m_dir);
    check("R6 pin_o", pout, m_out);
    check("R9 irq_o", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, m_irq});
  endtask

  task automatic wr(int a, logic [N-1:0] d);
    step(1'b1, a, d, pins);
  endtask

  task automatic rd(int a);
    step(1'b0, a, '0, pins);
  endtask

  task automatic idle(int n, logic [N-1:0] p);
    for (int k = 0; k < n; k++) step(1'b0, 10, '0, p);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; pins = '0;
    m_reset();
    repeat (3) @(negedge clk);
    // R1: outputs under reset
    check("R1 reset pin_o", pout, '0);
    check("R1 reset pin_oe_o", poe, '0);
    check("R1 reset irq_o", {15'd0, irq}, '0);
    rst_n = 1'b1;
    // R1: every register zero after release
    for (int a = 0; a < 16; a++) rd(a);

    // R2: low byte outputs
    wr(0, 16'h00FF);
    // R6: full load, R3 set, R4 clear, R5 toggle
    wr(1, 16'h00A5);
    wr(2, 16'h000F);
    wr(3, 16'h0003);
    wr(4, 16'h80FF);
    // R12: read same cycle as a write sees old value
    step(1'b1, 1, 16'h1234, pins);
    rd(1);
    // R7: sense for inputs delayed two clocks; write to sense address ignored
    idle(3, 16'hFF00);
    rd(5);
    wr(5, 16'hFFFF);
    rd(5); rd(0); rd(1);
    wr(12, 16'hFFFF);
    rd(12); rd(0); rd(1);

    // R8: enable set/clear
    wr(6, 16'hFFFF);
    wr(7, 16'h0F0F);
    rd(6); rd(7);
    // R9: level mode on inputs follows pin
    idle(4, 16'h0100);
    idle(4, 16'h0000);
    // R10: rising only on bit 8, both edges on bit 15
    wr(8, 16'hFF00);
    wr(9, 16'h8000);
    wr(6, 16'hFFFF);
    idle(4, 16'h8100);
    idle(4, 16'h0000);
    wr(10, 16'h0100);
    idle(2, 16'h0000);
    wr(10, 16'h8000);
    idle(2, 16'h0000);
    // R10: edge in same cycle as clear wins
    step(1'b0, 10, '0, 16'h8000);
    step(1'b0, 10, '0, 16'h8000);
    step(1'b1, 10, 16'h8000, 16'h8000);
    idle(2, 16'h8000);
    wr(10, 16'hFFFF);
    idle(2, 16'h8000);
    // R11: software edge on output pins in edge mode
    wr(8, 16'h00FF);
    wr(9, 16'h00F0);
    wr(3, 16'h00FF);
    wr(10, 16'hFFFF);
    wr(2, 16'h0011);
    idle(2, 16'h8000);
    wr(4, 16'h00FF);
    idle(2, 16'h8000);
    wr(7, 16'hFFFF);
    idle(2, 16'h8000);

    // random stretch, all requirements
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] p;
      p = ($urandom_range(0, 3) == 0) ? N'($urandom) : pins;
      step($urandom_range(0, 1) == 1, $urandom_range(0, 15), N'($urandom), p);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule